// File: doc/BRIEF.md
# Self Wake-Up Countdown Timer

This block is a one-shot down-counter that raises a wake-up interrupt when it expires. The counter runs on a slow, free-running timer clock. Software controls the block over a simple synchronous register bus clocked by the system clock. Writing a start value to the count register loads the counter and starts the countdown. When the count runs out, a sticky alarm flag is set, and that flag is the interrupt request. Software acknowledges the alarm by writing 1 to the flag. Software can also stop a running countdown through a self-clearing clear bit.

The count lives in the timer clock domain. The load, clear and expiry events cross between the two clocks as toggles through two-flop synchronizers. A live read of the count is taken straight from the timer domain, so it is not coherent. A read that lands on a timer clock edge can return a mixed value, and software should read twice and compare. The register bus has no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read strobe (`bus_sel` high, `bus_wr` low) returns its data on `bus_rdata` one system clock later, and that data holds until the next read strobe.

Top module: `swk_timer`

## Requirements
- R1: After reset, the control register and the count register both read 0, and `irq_o` is low.
- R2: A write of N to the count register (byte offset 0xC) starts a countdown. After the load has crossed to the timer domain, bit 1 of the control register (offset 0x0) is set once N timer clock ticks have elapsed.
- R3: A read of the count register returns the live count. The count decrements by exactly one per timer clock tick while the countdown runs.
- R4: At expiry the counter stops and holds at 0, and it never reloads. Once the flag is cleared, it stays clear until a new value is loaded.
- R5: `irq_o` follows the alarm flag: it is high exactly while control bit 1 reads 1.
- R6: Writing 1 to control bit 1 clears the flag. Writing 0 to control bit 1 leaves the flag unchanged.
- R7: Writing 1 to control bit 2 forces the count to 0 and halts counting without setting the flag. Bit 2 always reads 0.
- R8: Control bits 31:3 and bit 0 always read 0, and writes to them have no effect.
- R9: A count write during a running countdown replaces the current value and restarts the countdown from the new value.
- R10: Writing 0 to the count register sets the flag on the first timer tick after the load arrives.
- R11: Read data appears on `bus_rdata` on the system clock cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| tmr_clk | input | 1 | Slow timer clock that drives the countdown |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0xC count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read strobe |
| irq_o | output | 1 | Wake-up interrupt request (the alarm flag) |

## Verification
The bench checks the exact decrement between two reads taken a known number of timer ticks apart. A counter that skips ticks, or that decrements on both edges, fails this check. It loads 0 to confirm an immediate expiry; an off-by-one terminal test would either hang or wrap around to a huge count. It also checks that the flag stays clear after acknowledgement, which catches a design that reloads or keeps re-signalling expiry. It reloads during a running countdown to catch a design that ignores reloads. Finally it uses the clear bit to confirm the counter halts without raising an alarm, and that writes of 0 to the flag or to reserved bits do nothing.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'hC;
  localparam int unsigned ALARM_BIT = 1;
  localparam int unsigned HALT_BIT  = 2;
endpackage

// File: rtl/swk_tgl_sync.sv
// Toggle-to-pulse crossing: a level that flips once per event is resampled
// through STAGES flops in the destination clock and edge-detected.
module swk_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic dst_clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge dst_clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= tgl_in;
        end
      end else begin : g_next
        always_ff @(posedge dst_clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign pulse_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/swk_counter.sv
// Timer-domain one-shot down-counter.
module swk_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             tmr_clk,
  input  logic             rst_n,
  input  logic             load_p,
  input  logic             halt_p,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_o,
  output logic             exp_tgl_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             exp_tgl_q;
  logic             fire;

  assign fire = run_q && !load_p && !halt_p && (cnt_q <= ONE);

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      exp_tgl_q <= 1'b0;
    end else if (load_p) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (halt_p) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q <= ONE) begin
        cnt_q     <= '0;
        run_q     <= 1'b0;
        exp_tgl_q <= ~exp_tgl_q;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign count_o   = cnt_q;
  assign exp_tgl_o = exp_tgl_q;

  AST_DEC_BY_ONE: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (run_q && !load_p && !halt_p && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_EXPIRE_STOPS: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    fire |=> (!run_q && cnt_q == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (!run_q && !load_p && !halt_p) |=> ($stable(cnt_q) && $stable(exp_tgl_q))); // R4
  AST_HALT_CLEARS: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (halt_p && !load_p) |=> (cnt_q == '0 && !run_q && $stable(exp_tgl_q))); // R7
  AST_LOAD_TAKES: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    load_p |=> (cnt_q == $past(load_val) && run_q)); // R9
endmodule

// File: rtl/swk_regs.sv
// System-clock register file: alarm flag, halt and load commands, read mux.
module swk_regs
  import swk_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_live,
  input  logic              exp_p,
  output logic [CNT_W-1:0]  ld_val_o,
  output logic              ld_tgl_o,
  output logic              halt_tgl_o,
  output logic              alarm_o
);
  logic              wr_ctrl, wr_cnt, rd_stb;
  logic              alarm_q, ld_tgl_q, halt_tgl_q;
  logic [CNT_W-1:0]  ld_val_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign wr_cnt  = bus_sel && bus_wr && (bus_addr == OFS_COUNT);
  assign rd_stb  = bus_sel && !bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
    end else if (exp_p) begin
      alarm_q <= 1'b1;
    end else if (wr_ctrl && bus_wdata[ALARM_BIT]) begin
      alarm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_val_q <= '0;
      ld_tgl_q <= 1'b0;
    end else if (wr_cnt) begin
      ld_val_q <= bus_wdata[CNT_W-1:0];
      ld_tgl_q <= ~ld_tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              halt_tgl_q <= 1'b0;
    else if (wr_ctrl && bus_wdata[HALT_BIT]) halt_tgl_q <= ~halt_tgl_q;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_CTRL)       rd_mux[ALARM_BIT] = alarm_q;
    else if (bus_addr == OFS_COUNT) rd_mux[CNT_W-1:0] = cnt_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_mux;
  end

  assign bus_rdata  = rdata_q;
  assign ld_val_o   = ld_val_q;
  assign ld_tgl_o   = ld_tgl_q;
  assign halt_tgl_o = halt_tgl_q;
  assign alarm_o    = alarm_q;

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    exp_p |=> alarm_q); // R2
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[ALARM_BIT] && !exp_p) |=> !alarm_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !(wr_ctrl && bus_wdata[ALARM_BIT])) |=> alarm_q); // R6
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_q && !exp_p) |=> !alarm_q); // R4
  AST_CTRL_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && bus_addr == OFS_CTRL) |=> (bus_rdata[DATA_W-1:2] == '0 && !bus_rdata[0])); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(bus_rdata)); // R11
endmodule

// File: rtl/swk_timer.sv
module swk_timer
  import swk_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_clk,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_live, ld_val;
  logic ld_tgl, halt_tgl, exp_tgl;
  logic ld_p, halt_p, exp_p, alarm;

  swk_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_live(cnt_live), .exp_p(exp_p), .ld_val_o(ld_val),
    .ld_tgl_o(ld_tgl), .halt_tgl_o(halt_tgl), .alarm_o(alarm)
  );

  swk_tgl_sync #(.STAGES(SYNC_STGS)) u_ld_sync (
    .dst_clk(tmr_clk), .rst_n(rst_n), .tgl_in(ld_tgl), .pulse_o(ld_p)
  );

  swk_tgl_sync #(.STAGES(SYNC_STGS)) u_halt_sync (
    .dst_clk(tmr_clk), .rst_n(rst_n), .tgl_in(halt_tgl), .pulse_o(halt_p)
  );

  swk_tgl_sync #(.STAGES(SYNC_STGS)) u_exp_sync (
    .dst_clk(clk), .rst_n(rst_n), .tgl_in(exp_tgl), .pulse_o(exp_p)
  );

  swk_counter #(.CNT_W(CNT_W)) u_cnt (
    .tmr_clk(tmr_clk), .rst_n(rst_n), .load_p(ld_p), .halt_p(halt_p),
    .load_val(ld_val), .count_o(cnt_live), .exp_tgl_o(exp_tgl)
  );

  assign irq_o = alarm;

  AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == alarm); // R5
endmodule

// File: tb/swk_timer_tb_top.sv
module swk_timer_tb_top;
  logic        clk = 1'b0, tmr_clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_checks = 0, n_fail = 0;
  logic [31:0] last_rd;
  logic        rd_seen = 1'b0;

  typedef struct { logic [31:0] exp; logic [31:0] mask; string tag; } exp_t;
  exp_t sb_q[$];

  always #2   clk = ~clk;       // 250 MHz
  always #100 tmr_clk = ~tmr_clk;

  swk_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_clk(tmr_clk), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Monitor: a read strobe seen at a posedge yields data (R11) checked at the next negedge
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      last_rd = bus_rdata;
      if (it.mask != 0) begin
        n_checks++;
        if ((bus_rdata & it.mask) != (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s (R11 read path): actual %h expected %h", it.tag,
                   bus_rdata & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e,
                          input logic [31:0] m, input string tag);
    exp_t it;
    @(negedge clk);
    it.exp = e; it.mask = m; it.tag = tag;
    sb_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_t(input int n);
    repeat (n) @(negedge tmr_clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    chk(irq_o == e, tag, {31'b0, irq_o}, {31'b0, e});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #600000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v1, v2;
    #500 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R8: reset state
    bus_read(4'h0, 32'h0, 32'hFFFF_FFFF, "R1 ctrl after reset");
    bus_read(4'hC, 32'h0, 32'hFFFF_FFFF, "R1 count after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R2 / R3: countdown of 40
    bus_write(4'hC, 32'd40);
    wait_t(8);
    bus_read(4'hC, 32'h0, 32'h0, "R3 sample1");
    v1 = last_rd;
    wait_t(10);
    bus_read(4'hC, 32'h0, 32'h0, "R3 sample2");
    v2 = last_rd;
    chk(v1 - v2 == 32'd10, "R3 decrement per tick", v1 - v2, 32'd10);
    chk(v1 < 32'd40 && v1 > 32'd30, "R3 live count in range", v1, 32'd36);
    bus_read(4'h0, 32'h0, 32'h2, "R2 flag clear while running");
    wait_t(40);
    bus_read(4'h0, 32'h2, 32'hFFFF_FFFF, "R2 flag set at expiry");
    chk_irq(1'b1, "R5 irq high with flag");
    bus_read(4'hC, 32'h0, 32'hFFFF_FFFF, "R4 count holds zero");

    // R6: write-1-to-clear
    bus_write(4'h0, 32'h0);
    bus_read(4'h0, 32'h2, 32'hFFFF_FFFF, "R6 write 0 keeps flag");
    bus_write(4'h0, 32'h2);
    bus_read(4'h0, 32'h0, 32'hFFFF_FFFF, "R6 write 1 clears flag");
    chk_irq(1'b0, "R5 irq low after clear");
    wait_t(20);
    bus_read(4'h0, 32'h0, 32'hFFFF_FFFF, "R4 no re-alarm");
    bus_read(4'hC, 32'h0, 32'hFFFF_FFFF, "R4 no reload");

    // R10: load of zero
    bus_write(4'hC, 32'd0);
    wait_t(6);
    bus_read(4'h0, 32'h2, 32'hFFFF_FFFF, "R10 zero load expires");
    bus_write(4'h0, 32'h2);

    // R7: halt
    bus_write(4'hC, 32'd1000);
    wait_t(8);
    bus_write(4'h0, 32'h4);
    wait_t(6);
    bus_read(4'hC, 32'h0, 32'hFFFF_FFFF, "R7 halt zeroes count");
    wait_t(10);
    bus_read(4'hC, 32'h0, 32'hFFFF_FFFF, "R7 stays halted");
    bus_read(4'h0, 32'h0, 32'hFFFF_FFFF, "R7 no flag, bit2 reads 0");

    // R8: reserved bits ignored
    bus_write(4'h0, 32'hFFFF_FFF9);
    bus_read(4'h0, 32'h0, 32'hFFFF_FFFF, "R8 reserved bits read 0");
    bus_read(4'hC, 32'h0, 32'hFFFF_FFFF, "R8 count untouched");

    // R9: restart during countdown
    bus_write(4'hC, 32'd1000);
    wait_t(8);
    bus_write(4'hC, 32'd20);
    wait_t(30);
    bus_read(4'h0, 32'h2, 32'hFFFF_FFFF, "R9 reload restarts with new value");
    bus_read(4'hC, 32'h0, 32'hFFFF_FFFF, "R9 count zero after short run");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule